// File: doc/BRIEF.md
# Vector Dual Multiply-Accumulate Reduction

This block reduces two 128-bit vectors to one 64-bit sum of products. Each vector is split into eight 16-bit or four 32-bit elements. Each enabled element of the second vector is multiplied by an element of the first vector, and every such product is added into a 64-bit running total. The factors are sign-extended or zero-extended as selected.

With exchange off, each element pairs with its own counterpart. With exchange on, each element pairs with the neighbouring element of its even/odd pair in the first vector. A 16-bit per-byte predicate enables elements individually.

The caller holds the decoded controls and operands on the inputs and pulses `start`. The block then works through one element per clock and reports the total as two 32-bit halves together with a `done` pulse. The starting value of the total is either zero or the incoming accumulator. A skip-first-beat input forces the start from the incoming accumulator, whatever the accumulate control says.

Top module: `vec_dual_mac_reduce`

## Requirements
- R1: `wide_sel`=0 selects 16-bit elements (8 of them) and `wide_sel`=1 selects 32-bit elements (4 of them). Element e of a vector occupies bits [e*W +: W], where W is the element width.
- R2: Element e contributes only when `lane_pred` bit e*W/8 (the bit of its lowest byte) is 1. A disabled element still occupies its cycle but leaves the total unchanged.
- R3: With `xchg_sel`=0, each enabled element e adds `vec_a`[e] * `vec_b`[e].
- R4: With `xchg_sel`=1, an even element e adds `vec_a`[e+1] * `vec_b`[e], and an odd element e adds `vec_a`[e-1] * `vec_b`[e].
- R5: A start with `signed_sel`=0 and `xchg_sel`=1 is illegal. On the next cycle the block raises `illegal` for one cycle. It does not go busy, never pulses `done` for that request, and leaves the result outputs unchanged.
- R6: With `signed_sel`=1 both factors are sign-extended; with `signed_sel`=0 both are zero-extended. Each product is formed at 64 bits before it is added.
- R7: The total wraps modulo 2^64, with no saturation and no overflow indication.
- R8: With `acc_sel`=1 the total starts from `acc_in`; with `acc_sel`=0 and `skip_first`=0 it starts from zero.
- R9: With `skip_first`=1 the total starts from `acc_in`, even when `acc_sel`=0.
- R10: The result appears as `res_lo` (bits 31:0) and `res_hi` (bits 63:32). It changes only in the cycle `done` is high and holds until the next `done`. Reset clears it to zero.
- R11: An accepted start is sampled at a clock edge. `busy` is high from the next cycle on, and `done` is a single-cycle pulse exactly N clock edges after the start edge, where N is the element count.
- R12: A `start` seen while `busy` is high is ignored. It changes neither the result in progress nor its timing, and it raises no `illegal`.
- R13: An all-zero predicate returns the starting value of the total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; captures operands and controls |
| wide_sel | input | 1 | Element width: 0 = 16-bit, 1 = 32-bit |
| signed_sel | input | 1 | 1 = signed factors, 0 = unsigned |
| xchg_sel | input | 1 | Exchange neighbouring elements of `vec_a` |
| acc_sel | input | 1 | 1 = start from `acc_in`, 0 = start from zero |
| skip_first | input | 1 | First beat skipped: start from `acc_in` regardless |
| lane_pred | input | 16 | Per-byte enable mask |
| vec_a | input | 128 | First vector operand |
| vec_b | input | 128 | Second vector operand |
| acc_in | input | 64 | Incoming accumulator |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle pulse when the result is updated |
| illegal | output | 1 | One-cycle flag for a rejected request |
| res_lo | output | 32 | Result bits 31:0 |
| res_hi | output | 32 | Result bits 63:32 |

## Verification
A legal request sampled at edge T0 has its result and `done` due after edge T0+N, with N being 8 or 4 from the width control. A rejected request has `illegal` due after edge T0+1. The bench changes inputs and samples outputs on falling edges, counting edges from the start edge. It checks that `done` first appears on exactly the Nth falling edge and that the result is correct there. It then rechecks the result two cycles later to confirm that it holds. For rejected requests it watches N+1 cycles for a stray `done` and a changed result.

// File: rtl/vdmr_pkg.sv
`timescale 1ns/1ps
package vdmr_pkg;
   // Captured element mode of one request
   typedef struct packed {
      logic wide;
      logic sgn;
      logic xchg;
   } vdmr_mode_t;
endpackage

// File: rtl/vdmr_lane_pick.sv
`timescale 1ns/1ps
module vdmr_lane_pick #(
   parameter int VEC_W  = 128,
   parameter int LANE_W = 16,
   parameter int WIDE_W = 32,
   parameter int IDX_W  = 3,
   parameter int PIDX_W = 4
) (
   input  logic [VEC_W-1:0]   vec_a,
   input  logic [VEC_W-1:0]   vec_b,
   input  logic [VEC_W/8-1:0] pred,
   input  logic [IDX_W-1:0]   idx,
   input  logic               wide,
   input  logic               xchg,
   output logic [WIDE_W-1:0]  fac_a,
   output logic [WIDE_W-1:0]  fac_b,
   output logic               lane_en
);
   localparam int N_NAR  = VEC_W / LANE_W;
   localparam int N_WIDE = VEC_W / WIDE_W;
   localparam int WIDX_W = $clog2(N_WIDE);
   localparam int NB     = LANE_W / 8;
   localparam int WB     = WIDE_W / 8;

   logic [LANE_W-1:0] nar_a [N_NAR];
   logic [LANE_W-1:0] nar_b [N_NAR];
   logic [WIDE_W-1:0] wid_a [N_WIDE];
   logic [WIDE_W-1:0] wid_b [N_WIDE];

   generate
      for (genvar i = 0; i < N_NAR; i++) begin : g_nar
         assign nar_a[i] = vec_a[i*LANE_W +: LANE_W];
         assign nar_b[i] = vec_b[i*LANE_W +: LANE_W];
      end
      for (genvar j = 0; j < N_WIDE; j++) begin : g_wid
         assign wid_a[j] = vec_a[j*WIDE_W +: WIDE_W];
         assign wid_b[j] = vec_b[j*WIDE_W +: WIDE_W];
      end
   endgenerate

   logic [IDX_W-1:0]  src;
   logic [PIDX_W-1:0] pbit;

   always_comb begin
      // exchange flips the index LSB: even e -> e+1, odd e -> e-1
      src = idx ^ {{(IDX_W-1){1'b0}}, xchg};
      if (wide) begin
         fac_a = wid_a[src[WIDX_W-1:0]];
         fac_b = wid_b[idx[WIDX_W-1:0]];
         pbit  = PIDX_W'(idx) * PIDX_W'(WB);
      end else begin
         fac_a = WIDE_W'(nar_a[src]);
         fac_b = WIDE_W'(nar_b[idx]);
         pbit  = PIDX_W'(idx) * PIDX_W'(NB);
      end
      lane_en = pred[pbit];
   end
endmodule

// File: rtl/vdmr_prod.sv
`timescale 1ns/1ps
module vdmr_prod #(
   parameter int LANE_W = 16,
   parameter int WIDE_W = 32,
   parameter int ACC_W  = 64
) (
   input  logic [WIDE_W-1:0] fac_a,
   input  logic [WIDE_W-1:0] fac_b,
   input  logic              wide,
   input  logic              sgn,
   output logic [ACC_W-1:0]  prod
);
   localparam int PF_W = 2*WIDE_W + 2;

   logic signed [WIDE_W:0] xa, xb;
   logic signed [PF_W-1:0] pfull;

   always_comb begin
      if (wide) begin
         xa = {sgn & fac_a[WIDE_W-1], fac_a};
         xb = {sgn & fac_b[WIDE_W-1], fac_b};
      end else begin
         xa = {{(WIDE_W-LANE_W+1){sgn & fac_a[LANE_W-1]}}, fac_a[LANE_W-1:0]};
         xb = {{(WIDE_W-LANE_W+1){sgn & fac_b[LANE_W-1]}}, fac_b[LANE_W-1:0]};
      end
   end

   assign pfull = xa * xb;

   generate
      if (ACC_W > PF_W) begin : g_sext
         assign prod = {{(ACC_W-PF_W){pfull[PF_W-1]}}, pfull};
      end else begin : g_trunc
         assign prod = pfull[ACC_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/vdmr_seq.sv
`timescale 1ns/1ps
module vdmr_seq #(
   parameter int IDX_W  = 3,
   parameter int N_NAR  = 8,
   parameter int N_WIDE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             bad_req,
   input  logic             wide_q,
   output logic             accept,
   output logic             last,
   output logic [IDX_W-1:0] idx,
   output logic             busy,
   output logic             done,
   output logic             illegal
);
   assign accept = start & ~busy & ~bad_req;
   assign last   = busy & (idx == (wide_q ? IDX_W'(N_WIDE-1) : IDX_W'(N_NAR-1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         illegal <= 1'b0;
         idx     <= '0;
      end else begin
         done    <= last;
         illegal <= start & ~busy & bad_req;
         if (accept) begin
            busy <= 1'b1;
            idx  <= '0;
         end else if (busy) begin
            idx <= idx + IDX_W'(1);
            if (last) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/vec_dual_mac_reduce.sv
`timescale 1ns/1ps
module vec_dual_mac_reduce
   import vdmr_pkg::*;
#(
   parameter int VEC_W  = 128,
   parameter int LANE_W = 16,
   parameter int WIDE_W = 32,
   parameter int ACC_W  = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                wide_sel,
   input  logic                signed_sel,
   input  logic                xchg_sel,
   input  logic                acc_sel,
   input  logic                skip_first,
   input  logic [VEC_W/8-1:0]  lane_pred,
   input  logic [VEC_W-1:0]    vec_a,
   input  logic [VEC_W-1:0]    vec_b,
   input  logic [ACC_W-1:0]    acc_in,
   output logic                busy,
   output logic                done,
   output logic                illegal,
   output logic [ACC_W/2-1:0]  res_lo,
   output logic [ACC_W/2-1:0]  res_hi
);
   localparam int PRED_W = VEC_W / 8;
   localparam int N_NAR  = VEC_W / LANE_W;
   localparam int N_WIDE = VEC_W / WIDE_W;
   localparam int IDX_W  = $clog2(N_NAR);
   localparam int PIDX_W = $clog2(PRED_W);
   localparam int HALF_W = ACC_W / 2;

   generate
      if (LANE_W % 8 != 0 || WIDE_W != 2*LANE_W) begin : g_bad_lane
         $error("vec_dual_mac_reduce: wide element must be twice a byte-multiple narrow element");
      end
      if (VEC_W % WIDE_W != 0 || N_WIDE < 2) begin : g_bad_vec
         $error("vec_dual_mac_reduce: vector must hold at least two wide elements");
      end
      if (ACC_W < 2*WIDE_W || ACC_W % 2 != 0) begin : g_bad_acc
         $error("vec_dual_mac_reduce: accumulator narrower than a full product");
      end
   endgenerate

   vdmr_mode_t         mode_q;
   logic [VEC_W-1:0]   va_q, vb_q;
   logic [PRED_W-1:0]  pred_q;
   logic [ACC_W-1:0]   acc_q, acc_d, res_q, prod;
   logic [WIDE_W-1:0]  fac_a, fac_b;
   logic               lane_en, accept, last;
   logic [IDX_W-1:0]   idx;

   vdmr_seq #(.IDX_W(IDX_W), .N_NAR(N_NAR), .N_WIDE(N_WIDE)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .bad_req (~signed_sel & xchg_sel),
      .wide_q  (mode_q.wide),
      .accept  (accept),
      .last    (last),
      .idx     (idx),
      .busy    (busy),
      .done    (done),
      .illegal (illegal)
   );

   vdmr_lane_pick #(.VEC_W(VEC_W), .LANE_W(LANE_W), .WIDE_W(WIDE_W),
                    .IDX_W(IDX_W), .PIDX_W(PIDX_W)) u_pick (
      .vec_a   (va_q),
      .vec_b   (vb_q),
      .pred    (pred_q),
      .idx     (idx),
      .wide    (mode_q.wide),
      .xchg    (mode_q.xchg),
      .fac_a   (fac_a),
      .fac_b   (fac_b),
      .lane_en (lane_en)
   );

   vdmr_prod #(.LANE_W(LANE_W), .WIDE_W(WIDE_W), .ACC_W(ACC_W)) u_prod (
      .fac_a (fac_a),
      .fac_b (fac_b),
      .wide  (mode_q.wide),
      .sgn   (mode_q.sgn),
      .prod  (prod)
   );

   assign acc_d = acc_q + (lane_en ? prod : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         va_q   <= '0;
         vb_q   <= '0;
         pred_q <= '0;
         acc_q  <= '0;
         res_q  <= '0;
      end else begin
         if (accept) begin
            mode_q <= '{wide: wide_sel, sgn: signed_sel, xchg: xchg_sel};
            va_q   <= vec_a;
            vb_q   <= vec_b;
            pred_q <= lane_pred;
            acc_q  <= (acc_sel | skip_first) ? acc_in : '0;
         end else if (busy) begin
            acc_q <= acc_d;
         end
         if (last) res_q <= acc_d;
      end
   end

   assign res_lo = res_q[HALF_W-1:0];
   assign res_hi = res_q[ACC_W-1:HALF_W];
endmodule

// File: rtl/vdmr_checker.sv
`timescale 1ns/1ps
module vdmr_checker #(
   parameter int N_NAR  = 8,
   parameter int N_WIDE = 4,
   parameter int HALF_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              wide_sel,
   input logic              signed_sel,
   input logic              xchg_sel,
   input logic              busy,
   input logic              done,
   input logic              illegal,
   input logic [HALF_W-1:0] res_lo,
   input logic [HALF_W-1:0] res_hi
);
   localparam int CNT_W = $clog2(N_NAR + 1);

   logic             run_q;
   logic [CNT_W-1:0] cnt_q, exp_q;
   logic             take;

   assign take = start & ~busy & ~(~signed_sel & xchg_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         exp_q <= '0;
      end else if (take) begin
         run_q <= 1'b1;
         cnt_q <= '0;
         exp_q <= wide_sel ? CNT_W'(N_WIDE) : CNT_W'(N_NAR);
      end else if (run_q) begin
         if (done) run_q <= 1'b0;
         else      cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                   // R11
   AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_q && (cnt_q + CNT_W'(1)) == exp_q + CNT_W'(1) && cnt_q == exp_q)); // R11
   AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !signed_sel && xchg_sel) |=> (illegal && !busy)); // R5
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, illegal}));                                        // R5
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({res_hi, res_lo}));                              // R10
   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> !illegal);                                     // R12
endmodule

bind vec_dual_mac_reduce vdmr_checker #(
   .N_NAR  (N_NAR),
   .N_WIDE (N_WIDE),
   .HALF_W (HALF_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .wide_sel   (wide_sel),
   .signed_sel (signed_sel),
   .xchg_sel   (xchg_sel),
   .busy       (busy),
   .done       (done),
   .illegal    (illegal),
   .res_lo     (res_lo),
   .res_hi     (res_hi)
);

// File: tb/vec_dual_mac_reduce_test.sv
`timescale 1ns/1ps
module vec_dual_mac_reduce_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         wide_sel = 1'b0, signed_sel = 1'b0, xchg_sel = 1'b0;
   logic         acc_sel = 1'b0, skip_first = 1'b0;
   logic [15:0]  lane_pred = '0;
   logic [127:0] vec_a = '0, vec_b = '0;
   logic [63:0]  acc_in = '0;
   logic         busy, done, illegal;
   logic [31:0]  res_lo, res_hi;

   int           n_checks = 0;
   int           n_fail = 0;
   bit           finished = 0;
   logic [63:0]  prev_res = '0;

   always #2 clk = ~clk;

   vec_dual_mac_reduce uut (
      .clk(clk), .rst_n(rst_n), .start(start), .wide_sel(wide_sel),
      .signed_sel(signed_sel), .xchg_sel(xchg_sel), .acc_sel(acc_sel),
      .skip_first(skip_first), .lane_pred(lane_pred), .vec_a(vec_a),
      .vec_b(vec_b), .acc_in(acc_in), .busy(busy), .done(done),
      .illegal(illegal), .res_lo(res_lo), .res_hi(res_hi)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] model(input logic w, input logic s, input logic x,
                                         input logic ac, input logic sk,
                                         input logic [15:0] p, input logic [127:0] a,
                                         input logic [127:0] b, input logic [63:0] ai);
      logic [63:0] t, xa, xb;
      logic [31:0] ra, rb;
      int n, pe;
      n = w ? 4 : 8;
      t = (ac | sk) ? ai : 64'd0;
      for (int e = 0; e < n; e++) begin
         if (p[w ? e*4 : e*2]) begin
            pe = x ? (e ^ 1) : e;
            ra = w ? a[pe*32 +: 32] : {16'd0, a[pe*16 +: 16]};
            rb = w ? b[e*32 +: 32]  : {16'd0, b[e*16 +: 16]};
            if (w) begin
               xa = s ? {{32{ra[31]}}, ra} : {32'd0, ra};
               xb = s ? {{32{rb[31]}}, rb} : {32'd0, rb};
            end else begin
               xa = s ? {{48{ra[15]}}, ra[15:0]} : {48'd0, ra[15:0]};
               xb = s ? {{48{rb[15]}}, rb[15:0]} : {48'd0, rb[15:0]};
            end
            t = t + xa * xb;
         end
      end
      return t;
   endfunction

   // One request; poke=1 holds start an extra cycle with altered inputs while busy
   task automatic run_op(input logic w, input logic s, input logic x, input logic ac,
                         input logic sk, input logic [15:0] p, input logic [127:0] a,
                         input logic [127:0] b, input logic [63:0] ai,
                         input bit poke, input string tag);
      logic [63:0] exp;
      int n, first;
      n = w ? 4 : 8;
      exp = model(w, s, x, ac, sk, p, a, b, ai);
      @(negedge clk);
      wide_sel = w; signed_sel = s; xchg_sel = x; acc_sel = ac; skip_first = sk;
      lane_pred = p; vec_a = a; vec_b = b; acc_in = ai; start = 1'b1;
      @(negedge clk);
      if (!s && x) begin
         start = 1'b0;
         check(illegal && !busy, {tag, " R5 reject flag"}, {62'd0, illegal, busy}, 64'd2);
         first = 0;
         for (int k = 1; k <= n + 1; k++) begin
            @(negedge clk);
            if (done && first == 0) first = k;
         end
         check(first == 0, {tag, " R5 no done"}, 64'(first), 64'd0);
         check({res_hi, res_lo} == prev_res, {tag, " R5 result kept"}, {res_hi, res_lo}, prev_res);
         return;
      end
      if (poke) begin
         vec_a = ~a; vec_b = ~b; acc_in = ~ai; lane_pred = 16'hFFFF;
         acc_sel = ~ac; xchg_sel = 1'b1; signed_sel = 1'b0;
      end else begin
         start = 1'b0;
      end
      first = 0;
      for (int k = 1; k <= n; k++) begin
         if (k == 2) start = 1'b0;
         if (done && first == 0) first = k - 1;
         if (k > 1 && poke) check(!illegal, {tag, " R12 no reject while busy"}, {63'd0, illegal}, 64'd0);
         @(negedge clk);
      end
      start = 1'b0;
      if (done && first == 0) first = n;
      check(first == n && done, {tag, " R11 done timing"}, 64'(first), 64'(n));
      check({res_hi, res_lo} == exp, tag, {res_hi, res_lo}, exp);
      @(negedge clk);
      @(negedge clk);
      check({res_hi, res_lo} == exp && !busy && !done, {tag, " R10 result held"},
            {res_hi, res_lo}, exp);
      prev_res = exp;
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [127:0] a, b;
      repeat (3) @(negedge clk);
      check(!busy && !done && !illegal && {res_hi, res_lo} == 64'd0,
            "R10 reset state", {res_hi, res_lo}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: most negative 16-bit squared, eight times -> 2^33
      run_op(0, 1, 0, 0, 0, 16'hFFFF, {8{16'h8000}}, {8{16'h8000}}, 64'h0, 0, "R6 R1 neg16");
      // R7: most negative 32-bit squared, four times -> 2^64 wraps to acc
      run_op(1, 1, 0, 1, 0, 16'hFFFF, {4{32'h80000000}}, {4{32'h80000000}}, 64'h1234, 0, "R7 R6 neg32 wrap");
      // R6: all-ones unsigned 32-bit
      run_op(1, 0, 0, 0, 0, 16'hFFFF, {128{1'b1}}, {128{1'b1}}, 64'h0, 0, "R6 R1 ones32 unsigned");
      // R6: all-ones 16-bit signed is -1*-1
      run_op(0, 1, 0, 0, 0, 16'hFFFF, {128{1'b1}}, {128{1'b1}}, 64'h0, 0, "R6 ones16 signed");
      // R7: accumulator near the top wraps past zero
      run_op(0, 0, 0, 1, 0, 16'hFFFF, {8{16'hFFFF}}, {8{16'hFFFF}}, 64'hFFFF_FFFF_FFFF_FFF0, 0, "R7 wrap");
      // R13 / R8 / R9: zero mask returns the starting value
      run_op(0, 1, 0, 1, 0, 16'h0000, rnd128(), rnd128(), 64'hDEAD_BEEF_0123_4567, 0, "R13 R8 zero mask acc");
      run_op(1, 1, 0, 0, 1, 16'h0000, rnd128(), rnd128(), 64'hCAFE_F00D_8765_4321, 0, "R13 R9 zero mask skip");
      run_op(1, 0, 0, 0, 0, 16'h0000, rnd128(), rnd128(), 64'h5555_AAAA_5555_AAAA, 0, "R13 R8 zero mask zero start");
      // R4: distinct elements make the exchange pairing visible
      a = {16'd8, 16'd7, 16'd6, 16'd5, 16'd4, 16'd3, 16'd2, 16'd1};
      b = {16'd80, 16'd70, 16'd60, 16'd50, 16'd40, 16'd30, 16'd20, 16'd10};
      run_op(0, 1, 1, 0, 0, 16'hFFFF, a, b, 64'h0, 0, "R4 exchange 16");
      run_op(0, 1, 0, 0, 0, 16'hFFFF, a, b, 64'h0, 0, "R3 plain 16");
      run_op(1, 1, 1, 0, 0, 16'hFFFF, a, b, 64'h0, 0, "R4 exchange 32");
      // R2: only odd-byte bits set enables nothing; lowest-byte bits select elements
      run_op(0, 0, 0, 0, 0, 16'hAAAA, a, b, 64'h0, 0, "R2 odd byte bits");
      run_op(1, 0, 0, 0, 0, 16'h00F0, a, b, 64'h0, 0, "R2 one wide lane");
      run_op(1, 0, 0, 0, 0, 16'h4444, a, b, 64'h0, 0, "R2 non-lowest bytes");
      // R5: unsigned exchange rejected
      run_op(0, 0, 1, 1, 0, 16'hFFFF, a, b, 64'h77, 0, "R5 unsigned xchg");
      run_op(1, 0, 1, 0, 1, 16'hFFFF, a, b, 64'h77, 0, "R5 unsigned xchg wide");
      // R12: start held while busy is ignored
      run_op(0, 1, 0, 1, 0, 16'hF0F3, rnd128(), rnd128(), 64'h42, 1, "R12 busy start 16");
      run_op(1, 0, 0, 0, 0, 16'hFFFF, rnd128(), rnd128(), 64'h42, 1, "R12 busy start 32");

      // Mode sweep: every control combination with random data and masks
      for (int m = 0; m < 32; m++) begin
         for (int r = 0; r < 4; r++) begin
            run_op(m[0], m[1], m[2], m[3], m[4], 16'($urandom), rnd128(), rnd128(),
                   {$urandom, $urandom}, 0, "R1 R3 R4 R6 R8 R9 sweep");
         end
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule